// File: doc/BRIEF.md
# Phase-Difference Instantaneous Frequency Estimator

This block takes a stream of complex samples, the real part and its quadrature partner already aligned, and produces one instantaneous-frequency value per input sample. A pipelined vectoring rotator turns each complex pair into a phase angle. A wrap-removal stage then turns the sequence of angles into a continuous phase track. A symmetric difference over that track, taken two samples apart and scaled by 1/(4π), gives the frequency.

Angles use a binary code in which a full turn is 2^16 units, so π is 32768. Because π is a power of two, the wrap test is an exact compare and the 1/(4π) scale is a one-bit arithmetic shift. The output unit is fs/65536: a phasor that advances by s angle units per sample reads as s. The interface is a valid strobe with data in each direction, and there is no back-pressure. Idle cycles are simply skipped.

Top module: `phase_freq_est`

## Requirements
- R1: A synchronous active-high reset discards every sample in flight and all wrap and fill history. `out_vld` is low after reset and stays low until new samples have been accepted.
- R2: The phase is correct in all four quadrants, including inputs with negative real part. A phasor of amplitude 20000 that rotates through every quadrant in steps of 4000 units gives an output within ±8 of 4000 on every sample.
- R3: Each output equals (u[k] − u[k−2]) / 2, where u is the unwrapped phase in units of π/32768. For a constant per-sample step s this reads s within ±8, and a stationary phasor reads 0 within ±8.
- R4: The unwrapped phase has no 2π jumps. A rotation that crosses the ±π boundary, in either direction, produces no spike at the crossing.
- R5: The first two samples after reset produce no output. N accepted samples give N−2 outputs, in input order.
- R6: The output for sample k is valid exactly 18 clock edges after the edge that accepted sample k.
- R7: Cycles with `in_vld` low are ignored. They create no output and do not alter the values computed from the surrounding samples.
- R8: A per-sample step larger than half a turn reads as the equivalent negative step. A step of 49152 units (3/4 turn) reads −16384 within ±8.
- R9: Every output lies within ±32768, because each unwrapped step is bounded by ±π. A step of 30000 units reads 30000 within ±8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input sample strobe |
| in_re | input | 16 | Real part, signed |
| in_im | input | 16 | Imaginary part, signed |
| out_vld | output | 1 | Output strobe |
| out_freq | output | 17 | Frequency estimate, signed, LSB = fs/65536 |

## Verification
The hardest case to reach from the ports is the unwrap correction. It fires only when two consecutive phases straddle the ±π boundary, and its effect shows only as the absence of a spike several stages later. The stimulus therefore synthesizes phasors from chosen angle sequences that cross π going forward, going backward, and with steps above half a turn. Expected outputs come from the nominal angle steps, and the tolerance covers the arctangent approximation. Separate runs cover idle gaps and a reset issued mid-stream, which confirm that the pipeline drops the samples in flight and restarts its fill count.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
    parameter int IN_W   = 16;
    parameter int PH_W   = 16;
    parameter int ITERS  = 16;
    parameter int TURN_W = 8;

    localparam int XY_W      = IN_W + 2;
    localparam int UW        = PH_W + TURN_W;
    localparam int FQ_W      = PH_W + 1;
    localparam int LATENCY   = ITERS + 2;
    localparam int HALF_TURN = 1 << (PH_W - 1);
    localparam int QUARTER   = 1 << (PH_W - 2);

    typedef logic signed [XY_W-1:0] xy_t;
    typedef logic signed [PH_W-1:0] ang_t;
    typedef logic signed [UW-1:0]   uph_t;
    typedef logic signed [FQ_W-1:0] freq_t;

    typedef struct packed {
        logic vld;
        xy_t  x;
        xy_t  y;
        ang_t z;
    } vec_t;

    // arctan(2^-i) with pi = 2^30, rounded to the phase width in use
    function automatic ang_t atan_step(input int i);
        int fine;
        case (i)
            0:  fine = 268435456;
            1:  fine = 158466703;
            2:  fine = 83729454;
            3:  fine = 42502379;
            4:  fine = 21333665;
            5:  fine = 10677233;
            6:  fine = 5339921;
            7:  fine = 2670122;
            8:  fine = 1335082;
            9:  fine = 667543;
            10: fine = 333772;
            11: fine = 166886;
            12: fine = 83443;
            13: fine = 41722;
            14: fine = 20861;
            15: fine = 10430;
            16: fine = 5215;
            17: fine = 2608;
            18: fine = 1304;
            19: fine = 652;
            default: fine = 0;
        endcase
        fine = (fine + (1 << (30 - PH_W))) >>> (31 - PH_W);
        return ang_t'(fine);
    endfunction

    // fold the left half-plane onto the right one, seeding the angle
    function automatic vec_t pre_rotate(input logic v, input xy_t x, input xy_t y);
        vec_t r;
        r.vld = v;
        if (!x[XY_W-1]) begin
            r.x = x;   r.y = y;   r.z = '0;
        end else if (!y[XY_W-1]) begin
            r.x = y;   r.y = -x;  r.z = ang_t'(QUARTER);
        end else begin
            r.x = -y;  r.y = x;   r.z = ang_t'(-QUARTER);
        end
        return r;
    endfunction

    // one vectoring micro-rotation: drive y toward zero, accumulate angle
    function automatic vec_t micro_rot(input vec_t v, input int i);
        vec_t r;
        xy_t  xs;
        xy_t  ys;
        xs = v.x;
        ys = v.y;
        r  = v;
        if (!ys[XY_W-1]) begin
            r.x = xs + (ys >>> i);
            r.y = ys - (xs >>> i);
            r.z = v.z + atan_step(i);
        end else begin
            r.x = xs - (ys >>> i);
            r.y = ys + (xs >>> i);
            r.z = v.z - atan_step(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/pfe_cordic.sv
module pfe_cordic
    import pfe_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_vld,
    input  logic signed [IN_W-1:0] in_re,
    input  logic signed [IN_W-1:0] in_im,
    output logic                   ph_vld,
    output ang_t                   ph
);
    vec_t entry;
    vec_t stage [ITERS+1];

    always_comb entry = pre_rotate(in_vld, xy_t'(in_re), xy_t'(in_im));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k <= ITERS; k++) stage[k] <= '0;
        end else begin
            stage[0] <= entry;
            for (int i = 0; i < ITERS; i++) stage[i+1] <= micro_rot(stage[i], i);
        end
    end

    assign ph_vld = stage[ITERS].vld;
    assign ph     = stage[ITERS].z;
endmodule

// File: rtl/pfe_unwrap.sv
module pfe_unwrap
    import pfe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ph_vld,
    input  ang_t ph,
    output logic u_vld,
    output uph_t u_val
);
    localparam logic signed [PH_W:0] STEP_HI = (PH_W+1)'(HALF_TURN);
    localparam logic signed [PH_W:0] STEP_LO = -(PH_W+1)'(HALF_TURN);

    ang_t                     prev;
    logic                     have_prev;
    logic signed [TURN_W-1:0] turns;
    logic signed [TURN_W-1:0] turns_n;
    logic signed [PH_W:0]     step;
    uph_t                     u_n;

    always_comb begin
        step    = (PH_W+1)'(ph) - (PH_W+1)'(prev);
        turns_n = turns;
        if (have_prev) begin
            if (step > STEP_HI)      turns_n = turns - 1'b1;
            else if (step < STEP_LO) turns_n = turns + 1'b1;
        end
        u_n = uph_t'({turns_n, {PH_W{1'b0}}}) + uph_t'(ph);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            u_vld     <= 1'b0;
            have_prev <= 1'b0;
            turns     <= '0;
            prev      <= '0;
            u_val     <= '0;
        end else begin
            u_vld <= ph_vld;
            if (ph_vld) begin
                prev      <= ph;
                have_prev <= 1'b1;
                turns     <= turns_n;
                u_val     <= u_n;
            end
        end
    end
endmodule

// File: rtl/pfe_cdiff.sv
module pfe_cdiff
    import pfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  u_vld,
    input  uph_t  u_val,
    output logic  f_vld,
    output freq_t f_val
);
    uph_t       u1;
    uph_t       u2;
    logic [1:0] fill;
    uph_t       span;

    always_comb span = u_val - u2;

    always_ff @(posedge clk) begin
        if (rst) begin
            f_vld <= 1'b0;
            fill  <= '0;
            u1    <= '0;
            u2    <= '0;
            f_val <= '0;
        end else begin
            f_vld <= u_vld && (fill == 2'd2);
            if (u_vld) begin
                f_val <= freq_t'(span >>> 1);
                u2    <= u1;
                u1    <= u_val;
                if (fill != 2'd2) fill <= fill + 1'b1;
            end
        end
    end
endmodule

// File: rtl/phase_freq_est.sv
module phase_freq_est
    import pfe_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_vld,
    input  logic signed [IN_W-1:0] in_re,
    input  logic signed [IN_W-1:0] in_im,
    output logic                   out_vld,
    output logic signed [FQ_W-1:0] out_freq
);
    logic c_vld;
    ang_t c_ph;
    logic u_vld;
    uph_t u_val;

    pfe_cordic u_cordic (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_re(in_re), .in_im(in_im),
        .ph_vld(c_vld), .ph(c_ph)
    );

    pfe_unwrap u_unwrap (
        .clk(clk), .rst(rst), .ph_vld(c_vld), .ph(c_ph),
        .u_vld(u_vld), .u_val(u_val)
    );

    pfe_cdiff u_cdiff (
        .clk(clk), .rst(rst), .u_vld(u_vld), .u_val(u_val),
        .f_vld(out_vld), .f_val(out_freq)
    );
endmodule

// File: rtl/pfe_chk.sv
module pfe_chk
    import pfe_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  u_vld,
    input uph_t  u_val,
    input logic  out_vld,
    input freq_t out_freq
);
    localparam uph_t U_HALF = uph_t'(HALF_TURN);
    localparam freq_t F_HALF = freq_t'(HALF_TURN);

    uph_t       last_u;
    logic       have_u;
    logic [1:0] seen;
    uph_t       du;

    always_comb du = u_val - last_u;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_u <= 1'b0;
            seen   <= '0;
            last_u <= '0;
        end else if (u_vld) begin
            last_u <= u_val;
            have_u <= 1'b1;
            if (seen != 2'd3) seen <= seen + 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> !out_vld);

    // R4
    unwrap_step_chk: assert property (@(posedge clk) disable iff (rst)
        (u_vld && have_u) |-> (du <= U_HALF && du >= -U_HALF));

    // R5
    fill_suppress_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (seen == 2'd3));

    // R7
    out_follows_u_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(u_vld));

    // R9
    out_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (out_freq <= F_HALF && out_freq >= -F_HALF));
endmodule

bind phase_freq_est pfe_chk u_chk (
    .clk(clk), .rst(rst), .u_vld(u_vld), .u_val(u_val),
    .out_vld(out_vld), .out_freq(out_freq)
);

// File: tb/phase_freq_est_tb.sv
module phase_freq_est_tb;
    localparam int LAT = 18;
    localparam int TOL = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_vld = 1'b0;
    logic signed [15:0] in_re = '0;
    logic signed [15:0] in_im = '0;
    logic               out_vld;
    logic signed [16:0] out_freq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int ngot  = 0;
    bit done  = 1'b0;
    int got_f [1024];
    int got_c [1024];
    int th_a  [64];
    int sc_a  [64];

    phase_freq_est u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_re(in_re), .in_im(in_im),
        .out_vld(out_vld), .out_freq(out_freq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (out_vld && ngot < 1024) begin
            got_f[ngot] = int'(out_freq);
            got_c[ngot] = cyc;
            ngot = ngot + 1;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int wrapd(input int x);
        int m;
        m = ((x % 65536) + 65536 + 32768) % 65536;
        return m - 32768;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_vld = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_one(input int th, input int amp);
        real a;
        int  re;
        int  im;
        a  = 2.0 * 3.14159265358979 * th / 65536.0;
        re = $rtoi($floor(amp * $cos(a) + 0.5));
        im = $rtoi($floor(amp * $sin(a) + 0.5));
        in_re  = 16'(re);
        in_im  = 16'(im);
        in_vld = 1'b1;
    endtask

    task automatic run_case(input string req, input int start, input int step,
                            input int n, input int gap);
        int base;
        do_reset();
        base = ngot;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            th_a[i] = start + i * step;
            sc_a[i] = cyc;
            send_one(th_a[i], 20000);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_vld = 1'b0;
            end
        end
        @(negedge clk);
        in_vld = 1'b0;
        repeat (LAT + 8) @(negedge clk);
        // R5: N samples give N-2 outputs
        check(ngot - base == n - 2, {req, "/R5 count"}, ngot - base, n - 2);
        for (int j = 0; j + 2 < n && base + j < ngot; j++) begin
            int e;
            int a;
            e = (wrapd(th_a[j+2] - th_a[j+1]) + wrapd(th_a[j+1] - th_a[j])) / 2;
            a = got_f[base + j];
            check((a - e <= TOL) && (e - a <= TOL), {req, " value"}, a, e);
            // R6: fixed latency from acceptance to output
            check(got_c[base + j] - sc_a[j+2] == LAT + 1, {req, "/R6 latency"},
                  got_c[base + j] - sc_a[j+2], LAT + 1);
        end
    endtask

    task automatic t_reset();
        int base;
        do_reset();
        // R1: output idle right after reset
        check(out_vld == 1'b0, "R1 out_vld after reset", int'(out_vld), 0);
        // R1: samples in flight are discarded by a reset
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            send_one(i * 1000, 20000);
        end
        do_reset();
        base = ngot;
        repeat (LAT + 12) @(negedge clk);
        check(ngot == base, "R1 no output from flushed samples", ngot - base, 0);
        check(out_vld == 1'b0, "R1 out_vld idle", int'(out_vld), 0);
    endtask

    initial begin
        t_reset();
        run_case("R2 quadrant sweep", 1000, 4000, 20, 0);
        run_case("R3 stationary", 12345, 0, 8, 0);
        run_case("R3 slow rotation", 500, 700, 10, 0);
        run_case("R4 forward across pi", 20000, 2500, 30, 0);
        run_case("R4 backward across pi", -20000, -2500, 30, 0);
        run_case("R7 gapped input", 3000, 1234, 12, 3);
        run_case("R8 three-quarter step", 0, 49152, 10, 0);
        run_case("R9 near half-turn step", 100, 30000, 10, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule